// File: doc/BRIEF.md
# Register-to-Register Arithmetic Execution Core

This block is a small 8-bit execution core that runs only arithmetic and logic instructions whose operands sit in its own registers. It holds an accumulator, a packed flags byte, six general registers (B, C, D, E, H, L), a temp operand register and a program counter. Every instruction takes one machine cycle of four clocks. In the first clock the core presents the program counter on a fetch port. In the second it captures the opcode and advances the counter. In the third it copies the selected source register into temp. In the fourth it writes the result and the flags.

The ALU always takes the accumulator as its first operand and temp as its second. The supported operations are add, add with carry, subtract, subtract with borrow, AND, XOR, OR, compare, and increment and decrement of any register. Memory-operand forms and every unlisted opcode run as no-ops. The register file and flags are exposed as outputs, so a host can watch the results.

Top module: `regalu_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the accumulator, the flags and all general registers, and drops `mem_req`. The first fetch after reset reads address 0, with `mem_req` high in the second clock after reset is released.
- R2: `mem_req` is high for exactly one clock in every four. While it is high, `mem_addr` holds the fetch address. Each fetch address is one more than the previous one, modulo 2^ADDR_W.
- R3: Opcodes 0x80+r (ADD) and 0x88+r (ADC) add register r to A, and ADC also adds the incoming C. They give N=0, C = carry out of bit 7 and H = carry out of bit 3, with carry-in included.
- R4: Opcodes 0x90+r (SUB) and 0x98+r (SBC) subtract register r from A, and SBC also subtracts the incoming C. They give N=1, C = full borrow and H = borrow out of the low nibble.
- R5: 0xA0+r (AND) gives H=1, N=0, C=0. 0xA8+r (XOR) and 0xB0+r (OR) give N=0, H=0, C=0.
- R6: 0xB8+r (CP) sets the flags exactly as SUB would and leaves A unchanged.
- R7: INC (00rrr100) and DEC (00rrr101) write register r plus or minus one and keep the old C. INC gives N=0 with H = carry out of the low nibble. DEC gives N=1 with H = borrow out of the low nibble.
- R8: The flags byte is Z=bit 7, N=bit 6, H=bit 5, C=bit 4, and bits 3..0 are always zero. Z is 1 exactly when the 8-bit result is zero.
- R9: The 3-bit register code is 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 7=A. On `gpr_o`, B sits in bits 7:0, and C, D, E, H and L follow in ascending byte lanes.
- R10: Opcode 0x00, any opcode with register code 6 (memory source), and any opcode not listed above leave all registers and flags unchanged.
- R11: Registers and flags change only at the end of the fourth clock of a machine cycle. Values seen after the third clock still belong to the previous instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Opcode fetch address, registered |
| mem_req | output | 1 | One-clock fetch strobe |
| mem_rdata | input | 8 | Opcode byte returned for `mem_addr` |
| acc_o | output | DATA_W | Accumulator |
| flags_o | output | 8 | Flags byte Z,N,H,C,0,0,0,0 |
| gpr_o | output | 6*DATA_W | General registers, B in the lowest lane up to L |

## Verification
The bench builds the core with DATA_W=8 and ADDR_W=4. With a 16-entry address space, a program of a few dozen opcodes wraps the program counter twice, so the modulo behaviour of the fetch address is exercised without millions of cycles. The 8-bit datapath reaches the real carry, borrow and nibble boundaries: 0xFF+1, 0x0F+1, 0x10-1 and 0-1. The same opcode table also covers carry-in and borrow-in, CP leaving A alone, and a reset asserted in the middle of an instruction.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

  localparam int OPC_W  = 8;
  localparam int FLG_W  = 8;
  localparam int NIB_W  = 4;
  localparam int RCODE_W = 3;
  localparam int NUM_GPR = 6;

  // flag bit positions inside the packed flags byte
  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_C = 4;

  localparam logic [RCODE_W-1:0] RCODE_MEM = 3'd6;
  localparam logic [RCODE_W-1:0] RCODE_A   = 3'd7;

  typedef enum logic [1:0] {PH_T1, PH_T2, PH_T3, PH_T4} phase_e;

  typedef enum logic [3:0] {
    OP_NOP, OP_ADD, OP_ADC, OP_SUB, OP_SBC,
    OP_AND, OP_XOR, OP_OR,  OP_CP,  OP_INC, OP_DEC
  } alu_op_e;

  typedef struct packed {
    alu_op_e              op;
    logic                 load_tmp;
    logic                 store;
    logic [RCODE_W-1:0]   src;
    logic [RCODE_W-1:0]   dst;
  } ctl_t;

endpackage

// File: rtl/regalu_decode.sv
module regalu_decode
  import regalu_pkg::*;
(
  input  logic [OPC_W-1:0] ir,
  output ctl_t             ctl
);

  logic [1:0]         grp_hi;
  logic [RCODE_W-1:0] mid;
  logic [RCODE_W-1:0] low;

  assign grp_hi = ir[7:6];
  assign mid    = ir[5:3];
  assign low    = ir[2:0];

  always_comb begin
    ctl.op       = OP_NOP;
    ctl.load_tmp = 1'b0;
    ctl.store    = 1'b0;
    ctl.src      = '0;
    ctl.dst      = '0;
    if (grp_hi == 2'b10 && low != RCODE_MEM) begin
      // accumulator group: mid selects the operation, low the source
      ctl.load_tmp = 1'b1;
      ctl.src      = low;
      ctl.dst      = RCODE_A;
      ctl.store    = (mid != 3'd7);
      unique case (mid)
        3'd0: ctl.op = OP_ADD;
        3'd1: ctl.op = OP_ADC;
        3'd2: ctl.op = OP_SUB;
        3'd3: ctl.op = OP_SBC;
        3'd4: ctl.op = OP_AND;
        3'd5: ctl.op = OP_XOR;
        3'd6: ctl.op = OP_OR;
        default: ctl.op = OP_CP;
      endcase
    end else if (grp_hi == 2'b00 && mid != RCODE_MEM &&
                 (low == 3'b100 || low == 3'b101)) begin
      // step group: register is both source and destination
      ctl.op       = low[0] ? OP_DEC : OP_INC;
      ctl.load_tmp = 1'b1;
      ctl.store    = 1'b1;
      ctl.src      = mid;
      ctl.dst      = mid;
    end
  end

endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
  import regalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [FLG_W-1:0]  flags_in,
  output logic [DATA_W-1:0] result,
  output logic [FLG_W-1:0]  flags_out
);

  localparam logic [DATA_W:0] ONE_W = (DATA_W+1)'(1);
  localparam logic [NIB_W:0]  ONE_N = (NIB_W+1)'(1);

  logic [DATA_W:0] wide;
  logic [NIB_W:0]  nib;
  logic            ci;
  logic            fz, fn, fh, fc, upd;
  logic [DATA_W:0] wa, wb, wci;
  logic [NIB_W:0]  na, nb, nci;

  assign wa  = {1'b0, opa};
  assign wb  = {1'b0, opb};
  assign na  = {1'b0, opa[NIB_W-1:0]};
  assign nb  = {1'b0, opb[NIB_W-1:0]};
  assign wci = {{DATA_W{1'b0}}, ci};
  assign nci = {{NIB_W{1'b0}}, ci};

  always_comb begin
    ci = 1'b0;
    if (op == OP_ADC || op == OP_SBC) ci = flags_in[FLAG_C];
  end

  always_comb begin
    wide = wb;
    nib  = '0;
    fn   = 1'b0;
    fh   = 1'b0;
    fc   = 1'b0;
    upd  = 1'b1;
    unique case (op)
      OP_ADD, OP_ADC: begin
        wide = wa + wb + wci;
        nib  = na + nb + nci;
        fh   = nib[NIB_W];
        fc   = wide[DATA_W];
      end
      OP_SUB, OP_SBC, OP_CP: begin
        wide = wa - wb - wci;
        nib  = na - nb - nci;
        fn   = 1'b1;
        fh   = nib[NIB_W];
        fc   = wide[DATA_W];
      end
      OP_AND: begin
        wide = wa & wb;
        fh   = 1'b1;
      end
      OP_XOR: wide = wa ^ wb;
      OP_OR:  wide = wa | wb;
      OP_INC: begin
        wide = wb + ONE_W;
        nib  = nb + ONE_N;
        fh   = nib[NIB_W];
        fc   = flags_in[FLAG_C];
      end
      OP_DEC: begin
        wide = wb - ONE_W;
        nib  = nb - ONE_N;
        fn   = 1'b1;
        fh   = nib[NIB_W];
        fc   = flags_in[FLAG_C];
      end
      default: upd = 1'b0;
    endcase
  end

  assign fz     = (wide[DATA_W-1:0] == '0);
  assign result = wide[DATA_W-1:0];

  always_comb begin
    flags_out = '0;
    if (upd) begin
      flags_out[FLAG_Z] = fz;
      flags_out[FLAG_N] = fn;
      flags_out[FLAG_H] = fh;
      flags_out[FLAG_C] = fc;
    end else begin
      flags_out[FLAG_Z] = flags_in[FLAG_Z];
      flags_out[FLAG_N] = flags_in[FLAG_N];
      flags_out[FLAG_H] = flags_in[FLAG_H];
      flags_out[FLAG_C] = flags_in[FLAG_C];
    end
  end

endmodule

// File: rtl/regalu_regfile.sv
module regalu_regfile
  import regalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [RCODE_W-1:0]         waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [RCODE_W-1:0]         raddr,
  output logic [DATA_W-1:0]          rdata,
  output logic [DATA_W-1:0]          acc_o,
  output logic [NUM_GPR*DATA_W-1:0]  gpr_o
);

  localparam int NREG = 1 << RCODE_W;

  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata = regs[raddr];
  assign acc_o = regs[RCODE_A];

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_lane
    assign gpr_o[g*DATA_W +: DATA_W] = regs[g];
  end

endmodule

// File: rtl/regalu_core.sv
module regalu_core
  import regalu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic                       mem_req,
  input  logic [OPC_W-1:0]           mem_rdata,
  output logic [DATA_W-1:0]          acc_o,
  output logic [FLG_W-1:0]           flags_o,
  output logic [NUM_GPR*DATA_W-1:0]  gpr_o
);

  phase_e              phase_q;
  logic [ADDR_W-1:0]   pc_q;
  logic [OPC_W-1:0]    ir_q;
  logic [DATA_W-1:0]   temp_q;
  logic [FLG_W-1:0]    flags_q;
  ctl_t                ctl;
  logic [DATA_W-1:0]   rd_data;
  logic [DATA_W-1:0]   alu_res;
  logic [FLG_W-1:0]    alu_flags;
  logic                rf_we;

  regalu_decode u_dec (
    .ir  (ir_q),
    .ctl (ctl)
  );

  regalu_alu #(.DATA_W(DATA_W)) u_alu (
    .op        (ctl.op),
    .opa       (acc_o),
    .opb       (temp_q),
    .flags_in  (flags_q),
    .result    (alu_res),
    .flags_out (alu_flags)
  );

  assign rf_we = (phase_q == PH_T4) && ctl.store;

  regalu_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (ctl.dst),
    .wdata (alu_res),
    .raddr (ctl.src),
    .rdata (rd_data),
    .acc_o (acc_o),
    .gpr_o (gpr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_T1;
      pc_q     <= '0;
      mem_addr <= '0;
      mem_req  <= 1'b0;
      ir_q     <= '0;
      temp_q   <= '0;
      flags_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_T1: begin
          mem_addr <= pc_q;
          mem_req  <= 1'b1;
          phase_q  <= PH_T2;
        end
        PH_T2: begin
          mem_req <= 1'b0;
          ir_q    <= mem_rdata;
          pc_q    <= pc_q + ADDR_W'(1);
          phase_q <= PH_T3;
        end
        PH_T3: begin
          if (ctl.load_tmp) temp_q <= rd_data;
          phase_q <= PH_T4;
        end
        default: begin
          flags_q <= alu_flags;
          phase_q <= PH_T1;
        end
      endcase
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/regalu_checks.sv
module regalu_checks
  import regalu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         mem_addr,
  input logic                      mem_req,
  input logic [DATA_W-1:0]         acc_o,
  input logic [FLG_W-1:0]          flags_o,
  input logic [NUM_GPR*DATA_W-1:0] gpr_o,
  input logic [OPC_W-1:0]          ir
);

  // cycles since the last fetch strobe, saturating
  logic [1:0]        since_req;
  logic              seen_req;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_req <= '0;
      seen_req  <= 1'b0;
      last_addr <= '0;
    end else if (mem_req) begin
      since_req <= '0;
      seen_req  <= 1'b1;
      last_addr <= mem_addr;
    end else if (since_req != 2'd3) begin
      since_req <= since_req + 2'd1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!mem_req && acc_o == '0 && flags_o == '0 && gpr_o == '0));

  p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  p_req_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && seen_req) |-> since_req == 2'd3);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && seen_req) |-> mem_addr == last_addr + ADDR_W'(1));

  p_cp_keeps_acc_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_req && since_req == 2'd1 && ir[7:3] == 5'b10111) |=> $stable(acc_o));

  p_nop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (seen_req && since_req == 2'd1 && ir == 8'h00) |=>
      ($stable(acc_o) && $stable(flags_o) && $stable(gpr_o)));

  p_update_slot_r11: assert property (@(posedge clk) disable iff (rst)
    (seen_req && (!$stable(acc_o) || !$stable(flags_o) || !$stable(gpr_o)))
      |-> since_req == 2'd2);

endmodule

bind regalu_core regalu_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .mem_req  (mem_req),
  .acc_o    (acc_o),
  .flags_o  (flags_o),
  .gpr_o    (gpr_o),
  .ir       (ir_q)
);

// File: tb/test_regalu_core.sv
`timescale 1ns/1ps
module test_regalu_core;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int NV     = 37;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [ADDR_W-1:0]   mem_addr;
  logic                mem_req;
  logic [7:0]          mem_rdata;
  logic [DATA_W-1:0]   acc_o;
  logic [7:0]          flags_o;
  logic [6*DATA_W-1:0] gpr_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  logic [ADDR_W-1:0] exp_pc = '0;

  always #2 clk = ~clk;

  regalu_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regalu_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_req(mem_req),
    .mem_rdata(mem_rdata), .acc_o(acc_o), .flags_o(flags_o), .gpr_o(gpr_o)
  );

  // {opcode, register code to check, expected value, expected flags}
  localparam logic [27:0] VEC [NV] = '{
    28'h00_7_00_00, 28'h3C_7_01_00, 28'h05_0_FF_60, 28'h80_7_00_B0,
    28'h3C_7_01_10, 28'h88_7_01_30, 28'h0C_1_01_10, 28'h98_7_01_70,
    28'h91_7_00_C0, 28'hB8_7_00_70, 28'h3D_7_FF_70, 28'hA0_7_FF_20,
    28'hA8_7_00_80, 28'hB1_7_01_00, 28'h86_7_01_00, 28'h34_7_01_00,
    28'h2C_5_01_00, 28'h3E_7_01_00, 28'h0F_7_01_00, 28'h8D_7_02_00,
    28'h1C_3_01_00, 28'h24_4_01_00, 28'h25_4_00_C0, 28'h14_2_01_00,
    28'h87_7_04_00, 28'h87_7_08_00, 28'h87_7_10_20, 28'h3D_7_0F_60,
    28'h3C_7_10_20, 28'hB0_7_FF_00, 28'h3C_7_00_A0, 28'h9A_7_FF_70,
    28'h8B_7_01_30, 28'hAC_7_01_00, 28'h94_7_01_40, 28'hBF_7_01_C0,
    28'h97_7_00_C0
  };

  function automatic string req_of(input logic [7:0] op);
    if (op[7:6] == 2'b10 && op[2:0] == 3'd6) return "R10";
    if (op[7:6] == 2'b10) begin
      case (op[5:3])
        3'd0, 3'd1: return "R3";
        3'd2, 3'd3: return "R4";
        3'd7:       return "R6";
        default:    return "R5";
      endcase
    end
    if (op[7:6] == 2'b00 && op[5:3] != 3'd6 && op[2:1] == 2'b10) return "R7";
    return "R10";
  endfunction

  function automatic logic [7:0] reg_of(input logic [3:0] code);
    if (code == 4'd7) return acc_o;
    return gpr_o[code*8 +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // runs one machine cycle; starts and ends just after a falling edge
  task automatic exec(input logic [7:0] op);
    logic [7:0] a0, f0;
    mem_rdata = op;
    a0 = acc_o; f0 = flags_o;
    @(posedge clk); @(negedge clk);
    check(mem_req === 1'b1 && mem_addr === exp_pc, "R2", "fetch strobe/address",
          {mem_req, mem_addr}, {1'b1, exp_pc});
    @(posedge clk); @(negedge clk);
    check(mem_req === 1'b0, "R2", "strobe width", mem_req, 0);
    @(posedge clk); @(negedge clk);
    // R11: nothing visible before the fourth clock ends
    check(acc_o === a0 && flags_o === f0, "R11", "early update",
          {acc_o, flags_o}, {a0, f0});
    @(posedge clk); @(negedge clk);
    exp_pc = exp_pc + 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    mem_rdata = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(acc_o === 0 && flags_o === 0 && gpr_o === 0 && mem_req === 0, "R1",
          "reset state", {acc_o, flags_o, mem_req}, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] op, ev, ef;
      logic [3:0] rc;
      {op, rc, ev, ef} = VEC[i];
      exec(op);
      check(reg_of(rc) === ev, req_of(op), $sformatf("value step %0d op %0h", i, op),
            reg_of(rc), ev);
      check(flags_o === ef, req_of(op), $sformatf("flags step %0d op %0h", i, op),
            flags_o, ef);
    end

    // R9: final lane layout {L,H,E,D,C,B}
    check(gpr_o === 48'h01_00_01_01_01_FF, "R9", "register lanes", gpr_o,
          48'h01_00_01_01_01_FF);
    // R8: low flag nibble is zero after the whole program
    check(flags_o[3:0] === 4'h0, "R8", "flag low nibble", flags_o, 8'hC0);

    // R1: reset in the middle of an instruction
    mem_rdata = 8'h3C;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(acc_o === 0 && flags_o === 0 && gpr_o === 0 && mem_req === 0, "R1",
          "mid-instruction reset", {acc_o, flags_o, mem_req}, 0);
    @(negedge clk);
    rst = 1'b0;
    exp_pc = '0;
    exec(8'h3C);
    check(acc_o === 8'h01 && flags_o === 8'h00, "R1", "restart at address 0",
          {acc_o, flags_o}, 16'h0100);

    done = 1;
    summary();
    $finish;
  end

endmodule